// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches the write cycles on the device pins: an address, a data byte and an active-low write strobe, all synchronous to the core clock. It recognises keyed unlock sequences and turns each complete sequence into a single-clock request for the embedded algorithm engine. The requests are: byte program (with target address and data), chip erase, sector erase (with sector number), and return to read mode. An autoselect sequence sets a mode flag that stays set until a read/reset command clears it.

Every command opens with two keyed writes. The third write selects the operation. Byte program then takes a fourth write that carries the target address and data. An erase setup code instead demands a second keyed pair and then a final erase code. A write whose address or data does not fit the current step drops the decoder back to idle. While the algorithm engine reports busy, writes have no effect on the decoder. The memory array, the erase and program timing and the read path are outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `prog_req`, `erase_req`, `reset_req` and `autosel` are all 0.
- R2: A write is accepted on the rising edge of `we_n`, using the address and data present while `we_n` was low. The request it causes appears in the clock after the clock that sees `we_n` high again, and never while `we_n` is still low.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A give one `prog_req` pulse with `prog_addr`=A and `prog_data`=D.
- R4: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set `autosel` to 1. It stays 1 through other commands until a reset command is accepted.
- R5: A single write of F0h to any address, or F0h as the third write of a keyed sequence, gives one `reset_req` pulse and clears `autosel`.
- R6: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h give one `erase_req` pulse with `erase_chip`=1.
- R7: The same first five writes followed by 30h@A give one `erase_req` pulse with `erase_chip`=0 and `erase_sector` set to the top SECT_W bits of A (A[16:14] by default).
- R8: A write that does not fit the current step returns the decoder to idle with no request. The writes that follow cause no request unless they start over with AAh@5555h.
- R9: Only address bits [14:0] are compared with the keyed addresses 5555h and 2AAAh, so 15555h and 12AAAh are also accepted.
- R10: While `busy` is 1, writes cause no request and do not advance the sequence. A complete program sequence written during busy gives no `prog_req`.
- R11: Each request is exactly one clock wide, and at most one of `prog_req`, `erase_req`, `reset_req` is 1 in any cycle.
- R12: In the program data step, the value F0h is programmed like any other byte and does not give `reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we_n | input | 1 | Active-low write strobe, synchronous to clk |
| addr | input | ADDR_W (17) | Write address |
| wdata | input | 8 | Write data |
| busy | input | 1 | Embedded algorithm engine is running |
| prog_req | output | 1 | One-clock byte program request |
| prog_addr | output | ADDR_W (17) | Address to program |
| prog_data | output | 8 | Byte to program |
| erase_req | output | 1 | One-clock erase request |
| erase_chip | output | 1 | 1 = whole chip, 0 = one sector |
| erase_sector | output | SECT_W (3) | Sector number for sector erase |
| autosel | output | 1 | Autoselect mode flag |
| reset_req | output | 1 | One-clock return-to-read request |

## Verification
The assertions assume the following about the inputs:
- `we_n` is already synchronous to `clk`.
- Each low phase and each high phase of `we_n` lasts at least one clock.
- `addr` and `wdata` hold steady while `we_n` is low.
- `busy` changes only on clock boundaries.

Under these assumptions a write is seen as exactly one rising-edge event, and the latched data matches the data on the pins one cycle earlier. The bench drives all inputs on the falling clock edge. It holds each strobe low for one or more full clocks and then high for a clock, so it never presents a glitch or a strobe shorter than a clock. It also keeps `busy` steady across each whole write.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] CODE_KEY_A   = 8'hAA;
  localparam logic [DATA_W-1:0] CODE_KEY_B   = 8'h55;
  localparam logic [DATA_W-1:0] CODE_READ    = 8'hF0;
  localparam logic [DATA_W-1:0] CODE_IDENT   = 8'h90;
  localparam logic [DATA_W-1:0] CODE_PROG    = 8'hA0;
  localparam logic [DATA_W-1:0] CODE_ERSETUP = 8'h80;
  localparam logic [DATA_W-1:0] CODE_CHIP    = 8'h10;
  localparam logic [DATA_W-1:0] CODE_SECTOR  = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_CMD,
    ST_PDATA,
    ST_ESETUP,
    ST_EKEY1,
    ST_ECODE
  } seq_state_t;

endpackage

// File: rtl/fcd_reset_sync.sv
module fcd_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/fcd_strobe_capture.sv
module fcd_strobe_capture
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_ev,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);

  logic              we_q;
  logic              lat_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // address and data are held while the strobe is low
  assign lat_en = ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (lat_en) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  // rising edge of the write strobe
  assign wr_ev   = ~we_q & we_n;
  assign ev_addr = addr_q;
  assign ev_data = data_q;

  assert_ev_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |-> (ev_data == $past(wdata)) && (ev_addr == $past(addr)));

endmodule

// File: rtl/fcd_key_match.sv
module fcd_key_match #(
  parameter int KEY_W = 15
) (
  input  logic [KEY_W-1:0] key_addr,
  output logic             hit_first,
  output logic             hit_second
);

  localparam logic [KEY_W-1:0] KEY_ADDR_1 = KEY_W'(16'h5555);
  localparam logic [KEY_W-1:0] KEY_ADDR_2 = KEY_W'(16'h2AAA);

  assign hit_first  = (key_addr == KEY_ADDR_1);
  assign hit_second = (key_addr == KEY_ADDR_2);

endmodule

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              hit_first,
  input  logic              hit_second,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sector,
  output logic              autosel,
  output logic              reset_req
);

  seq_state_t        state_q, state_d;
  logic              take;
  logic              prog_fire, erase_fire, chip_sel, rst_fire, asel_set;
  logic              prog_q, erase_q, chip_q, rstr_q, asel_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic [SECT_W-1:0] sect_q;

  assign take = wr_ev & ~busy;

  always_comb begin
    state_d    = state_q;
    prog_fire  = 1'b0;
    erase_fire = 1'b0;
    chip_sel   = 1'b0;
    rst_fire   = 1'b0;
    asel_set   = 1'b0;
    if (take) begin
      if (ev_data == CODE_READ && state_q != ST_PDATA) begin
        rst_fire = 1'b1;
        state_d  = ST_IDLE;
      end else begin
        state_d = ST_IDLE;
        unique case (state_q)
          ST_IDLE:   if (hit_first && ev_data == CODE_KEY_A) state_d = ST_KEY1;
          ST_KEY1:   if (hit_second && ev_data == CODE_KEY_B) state_d = ST_CMD;
          ST_CMD: begin
            if (hit_first) begin
              if (ev_data == CODE_IDENT)   asel_set = 1'b1;
              if (ev_data == CODE_PROG)    state_d  = ST_PDATA;
              if (ev_data == CODE_ERSETUP) state_d  = ST_ESETUP;
            end
          end
          ST_PDATA:  prog_fire = 1'b1;
          ST_ESETUP: if (hit_first && ev_data == CODE_KEY_A) state_d = ST_EKEY1;
          ST_EKEY1:  if (hit_second && ev_data == CODE_KEY_B) state_d = ST_ECODE;
          ST_ECODE: begin
            if (hit_first && ev_data == CODE_CHIP) begin
              erase_fire = 1'b1;
              chip_sel   = 1'b1;
            end else if (ev_data == CODE_SECTOR) begin
              erase_fire = 1'b1;
            end
          end
          default:   state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      rstr_q  <= 1'b0;
    end else begin
      prog_q  <= prog_fire;
      erase_q <= erase_fire;
      rstr_q  <= rst_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      pdata_q <= '0;
    end else if (prog_fire) begin
      paddr_q <= ev_addr;
      pdata_q <= ev_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= 1'b0;
      sect_q <= '0;
    end else if (erase_fire) begin
      chip_q <= chip_sel;
      sect_q <= ev_addr[ADDR_W-1 -: SECT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        asel_q <= 1'b0;
    else if (rst_fire) asel_q <= 1'b0;
    else if (asel_set) asel_q <= 1'b1;
  end

  assign prog_req     = prog_q;
  assign prog_addr    = paddr_q;
  assign prog_data    = pdata_q;
  assign erase_req    = erase_q;
  assign erase_chip   = chip_q;
  assign erase_sector = sect_q;
  assign autosel      = asel_q;
  assign reset_req    = rstr_q;

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, reset_req}));

  assert_prog_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  assert_erase_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  assert_req_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req || reset_req) |-> $past(wr_ev));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_req) |-> !$past(busy));

  assert_asel_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(autosel) |-> reset_req);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int KEY_W  = 15,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sector,
  output logic              autosel,
  output logic              reset_req
);

  logic              rst_n;
  logic              wr_ev;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data;
  logic              hit_first, hit_second;

  fcd_reset_sync i_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  fcd_strobe_capture #(.ADDR_W(ADDR_W)) i_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_n    (we_n),
    .addr    (addr),
    .wdata   (wdata),
    .wr_ev   (wr_ev),
    .ev_addr (ev_addr),
    .ev_data (ev_data)
  );

  fcd_key_match #(.KEY_W(KEY_W)) i_key (
    .key_addr   (ev_addr[KEY_W-1:0]),
    .hit_first  (hit_first),
    .hit_second (hit_second)
  );

  fcd_cmd_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ev        (wr_ev),
    .ev_addr      (ev_addr),
    .ev_data      (ev_data),
    .hit_first    (hit_first),
    .hit_second   (hit_second),
    .busy         (busy),
    .prog_req     (prog_req),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .erase_req    (erase_req),
    .erase_chip   (erase_chip),
    .erase_sector (erase_sector),
    .autosel      (autosel),
    .reset_req    (reset_req)
  );

endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        we_n;
  logic [16:0] addr;
  logic [7:0]  wdata;
  logic        busy;
  logic        prog_req, erase_req, erase_chip, autosel, reset_req;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  erase_sector;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .arst_n(arst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_req(erase_req), .erase_chip(erase_chip),
    .erase_sector(erase_sector), .autosel(autosel), .reset_req(reset_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // one write: strobe low for 'hold' clocks, then high; returns at the
  // falling edge after the clock that saw the rising strobe
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    we_n = 1'b0; addr = a; wdata = d;
    repeat (hold) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic keys;
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic no_req(input string req);
    chk(req, "prog_req", prog_req, 0);
    chk(req, "erase_req", erase_req, 0);
    chk(req, "reset_req", reset_req, 0);
  endtask

  task automatic t_reset;
    no_req("R1");
    chk("R1", "autosel", autosel, 0);
  endtask

  task automatic t_program;
    keys();
    wr(17'h05555, 8'hA0);
    chk("R3", "prog_req early", prog_req, 0);
    // last write with a long low phase
    @(negedge clk);
    we_n = 1'b0; addr = 17'h1ABCD; wdata = 8'h5A;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "prog_req while strobe low", prog_req, 0);
    end
    we_n = 1'b1;
    @(negedge clk);
    chk("R3", "prog_req", prog_req, 1);
    chk("R3", "prog_addr", prog_addr, 17'h1ABCD);
    chk("R3", "prog_data", prog_data, 8'h5A);
    chk("R11", "only prog", {erase_req, reset_req}, 0);
    @(negedge clk);
    chk("R11", "prog_req width", prog_req, 0);
  endtask

  task automatic t_program_f0;
    keys();
    wr(17'h05555, 8'hA0);
    wr(17'h00300, 8'hF0);
    chk("R12", "prog_req", prog_req, 1);
    chk("R12", "prog_data", prog_data, 8'hF0);
    chk("R12", "reset_req", reset_req, 0);
  endtask

  task automatic t_autosel;
    keys();
    wr(17'h05555, 8'h90);
    chk("R4", "autosel set", autosel, 1);
    keys();
    wr(17'h05555, 8'hA0);
    wr(17'h00010, 8'h11);
    chk("R4", "autosel held", autosel, 1);
    wr(17'h00123, 8'hF0);
    chk("R5", "single F0 reset_req", reset_req, 1);
    chk("R5", "autosel cleared", autosel, 0);
    keys();
    wr(17'h05555, 8'h90);
    chk("R4", "autosel set again", autosel, 1);
    keys();
    wr(17'h05555, 8'hF0);
    chk("R5", "keyed F0 reset_req", reset_req, 1);
    chk("R5", "autosel cleared keyed", autosel, 0);
  endtask

  task automatic t_chip;
    keys();
    wr(17'h05555, 8'h80);
    keys();
    wr(17'h05555, 8'h10);
    chk("R6", "erase_req", erase_req, 1);
    chk("R6", "erase_chip", erase_chip, 1);
    @(negedge clk);
    chk("R11", "erase_req width", erase_req, 0);
  endtask

  task automatic t_sector;
    logic [16:0] a;
    a = 17'h1A000;
    keys();
    wr(17'h05555, 8'h80);
    keys();
    wr(a, 8'h30);
    chk("R7", "erase_req", erase_req, 1);
    chk("R7", "erase_chip", erase_chip, 0);
    chk("R7", "erase_sector", erase_sector, a >> 14);
  endtask

  task automatic t_abort;
    wr(17'h05555, 8'hAA);
    wr(17'h01234, 8'h55);
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h77);
    no_req("R8");
    keys();
    wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA);
    wr(17'h05555, 8'h55);
    wr(17'h05555, 8'h10);
    no_req("R8");
    keys();
    wr(17'h05555, 8'hA0);
    wr(17'h00100, 8'h77);
    chk("R8", "fresh program after abort", prog_req, 1);
  endtask

  task automatic t_addr_mask;
    wr(17'h15555, 8'hAA);
    wr(17'h12AAA, 8'h55);
    wr(17'h15555, 8'hA0);
    wr(17'h00042, 8'h3C);
    chk("R9", "prog_req high-bit keys", prog_req, 1);
    chk("R9", "prog_addr", prog_addr, 17'h00042);
  endtask

  task automatic t_busy;
    busy = 1'b1;
    keys();
    wr(17'h05555, 8'hA0);
    wr(17'h00777, 8'h99);
    no_req("R10");
    wr(17'h00777, 8'h99);
    no_req("R10");
    busy = 1'b0;
    wr(17'h00777, 8'h99);
    chk("R10", "no advance during busy", prog_req, 0);
    keys();
    wr(17'h05555, 8'hA0);
    wr(17'h00777, 8'h99);
    chk("R10", "prog after busy", prog_req, 1);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    arst_n = 1'b0; we_n = 1'b1; addr = '0; wdata = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_program_f0();
    t_autosel();
    t_chip();
    t_sector();
    t_abort();
    t_addr_mask();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule